// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point operands and returns their sum in the same format. An operand has a sign bit in bit 31, where 0 means positive and 1 means negative. It has an 8-bit exponent in bits 30:23, biased by 127, and a 23-bit fraction in bits 22:0. Its value is (-1)^sign × (1 + fraction) × 2^(exponent − 127). Any operand whose exponent field is zero is treated as zero.

The datapath is a single combinational stage followed by one output register. It first splits each operand into its fields and prepends the hidden 1. It then orders the operands by magnitude and shifts the smaller significand right by the exponent difference. The bits shifted out are kept as guard, round and sticky bits. The significands are then added or subtracted, the sum is normalised, and it is rounded under one of four directions chosen per operation. Results outside the finite normal range raise an overflow or underflow flag.

A caller presents the operands with a one-cycle valid strobe. The registered result appears with its own strobe on the next clock edge. Between results, the output holds its last value.

Top module: `fp32_adder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and is low otherwise. A synchronous active-low reset clears `out_valid`, `sum`, `ovf_flag` and `unf_flag` to zero.
- R2: For normal operands, `sum` is the exact sum rounded to the 24-bit significand under the selected direction. The result sign is that of the larger-magnitude operand. Under nearest, 0xF2D20004 + 0x76407020 gives 0x763ECC20; toward zero, the same pair gives 0x763ECC1F.
- R3: `rnd_mode` selects the rounding direction: 0 is nearest, 1 is toward +infinity, 2 is toward −infinity, and 3 is toward zero. Toward zero never increases the magnitude, so 0xBE99999A + 0x2B800000 gives 0xBE999999.
- R4: Under nearest, a result exactly halfway between two representable values goes to the one with an even last fraction bit. So 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: An operand with exponent field zero counts as zero whatever its fraction. The sum of such an operand and a normal operand is the normal operand, unchanged.
- R6: An exactly zero sum, from cancellation or from two zero operands, is 0x00000000. Under mode 2 it is 0x80000000. Neither flag is raised.
- R7: When the rounded exponent reaches 255, `ovf_flag` is set. The result is infinity (exponent 0xFF, fraction 0) of the result sign under mode 0, under mode 1 for a positive result, and under mode 2 for a negative result. In all other cases the result is the largest finite magnitude, 0x7F7FFFFF with the result sign.
- R8: When the rounded exponent is 0 or below for a nonzero sum, `unf_flag` is set and `sum` is a zero carrying the result sign. The block never outputs a nonzero fraction with exponent field zero.
- R9: When the exponent difference is 26 or more, the smaller operand acts only as a sticky bit. For example, 0x3F800000 + 0x30800000 gives 0x3F800000 under modes 0 and 2, and 0x3F800001 under mode 1.
- R10: In a cycle after one with `in_valid` low, `sum`, `ovf_flag` and `unf_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding direction (0 nearest, 1 up, 2 down, 3 toward zero) |
| out_valid | output | 1 | `sum` and flags hold a new result |
| sum | output | 32 | Registered rounded sum |
| ovf_flag | output | 1 | Result exceeded the finite range |
| unf_flag | output | 1 | Nonzero result fell below the normal range |

## Verification
The assertions check some properties on every clock cycle. They check the one-cycle relation between the two strobes and that the output holds between results. They check that the overflow and underflow flags are never raised together. They also check that a flagged result has the saturated or zero encoding, and that no result ever has a zero exponent with a nonzero fraction. Other properties show only through the bench's scenarios, which compare every cycle against an exact wide-integer model. These are the correctness of the rounded value in each direction, ties to even, sticky-only alignment at large exponent differences, the sign of an exact zero, and the choice between infinity and the largest finite value on overflow.

// File: rtl/fpadd_pkg.sv
// Shared definitions for the floating-point adder.
// Assumes: rounding codes are fixed by the top-level port encoding.
package fpadd_pkg;

    // Rounding direction codes as seen on the rnd_mode port.
    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_UP      = 2'd1,
        RND_DOWN    = 2'd2,
        RND_TRUNC   = 2'd3
    } rnd_mode_e;

    // Decide whether the kept significand must be incremented by one unit.
    function automatic logic need_increment(rnd_mode_e mode, logic sign,
                                            logic lsb, logic guard, logic rest);
        logic inexact;
        inexact = guard | rest;
        case (mode)
            RND_NEAREST: need_increment = guard & (rest | lsb);
            RND_UP:      need_increment = inexact & ~sign;
            RND_DOWN:    need_increment = inexact & sign;
            default:     need_increment = 1'b0;
        endcase
    endfunction

    // True when an overflowing result becomes infinity rather than the largest finite value.
    function automatic logic overflow_to_inf(rnd_mode_e mode, logic sign);
        case (mode)
            RND_NEAREST: overflow_to_inf = 1'b1;
            RND_UP:      overflow_to_inf = ~sign;
            RND_DOWN:    overflow_to_inf = sign;
            default:     overflow_to_inf = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpadd_field_split.sv
// Splits one packed operand into sign, exponent and significand.
// The hidden 1 is restored here. An operand with a zero exponent field is
// treated as zero: its significand is forced to zero and the fraction is ignored.
module fpadd_field_split #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  exp_f,
    output logic [SIG_W-1:0]  sig,
    output logic              is_zero
);

    // Field extraction and hidden-bit restoration.
    always_comb begin
        sign    = word[WORD_W-1];
        exp_f   = word[WORD_W-2 -: EXP_W];
        is_zero = (exp_f == '0);
        sig     = is_zero ? '0 : {1'b1, word[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fpadd_align.sv
// Orders the two operands by magnitude and aligns the smaller significand.
// Output significands are extended by guard, round and sticky bits. The
// sticky bit collects every bit shifted past the round position.
// Assumes: a zero operand arrives with a zero exponent and a zero significand.
module fpadd_align #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3
) (
    input  logic              sign_a,
    input  logic [EXP_W-1:0]  exp_a,
    input  logic [SIG_W-1:0]  sig_a,
    input  logic              sign_b,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic [SIG_W-1:0]  sig_b,
    output logic              res_sign,
    output logic              eff_sub,
    output logic [EXP_W-1:0]  big_exp,
    output logic [EXT_W-1:0]  big_ext,
    output logic [EXT_W-1:0]  small_ext
);

    localparam int KEEP_W = SIG_W + 2;          // significand plus guard and round
    localparam int SPAN_W = SIG_W + KEEP_W;     // room for every shifted-out bit

    logic              a_big;
    logic [EXP_W-1:0]  small_exp;
    logic [EXP_W-1:0]  diff;
    logic [SIG_W-1:0]  big_sig;
    logic [SIG_W-1:0]  small_sig;
    logic [SPAN_W-1:0] spread;
    logic [KEEP_W-1:0] kept;
    logic              sticky;

    // Magnitude ordering: exponent first, then significand.
    always_comb begin
        a_big     = {exp_a, sig_a} >= {exp_b, sig_b};
        big_exp   = a_big ? exp_a : exp_b;
        small_exp = a_big ? exp_b : exp_a;
        big_sig   = a_big ? sig_a : sig_b;
        small_sig = a_big ? sig_b : sig_a;
        res_sign  = a_big ? sign_a : sign_b;
        eff_sub   = sign_a ^ sign_b;
        diff      = big_exp - small_exp;
    end

    // Right shift of the smaller significand with sticky collapse.
    always_comb begin
        spread = {small_sig, {KEEP_W{1'b0}}} >> diff;
        if (diff >= EXP_W'(KEEP_W)) begin
            kept   = '0;
            sticky = |small_sig;
        end else begin
            kept   = spread[SPAN_W-1 -: KEEP_W];
            sticky = |spread[SIG_W-1:0];
        end
        small_ext = {kept, sticky};
        big_ext   = {big_sig, 3'b000};
    end

endmodule

// File: rtl/fpadd_addnorm.sv
// Adds or subtracts the aligned significands and normalises the result so
// that its top bit is the leading 1. A carry-out shifts right by one and folds
// the lost bit into sticky. Cancellation shifts left by the leading-zero count.
// Assumes: big_ext has magnitude >= small_ext, so subtraction never goes negative.
module fpadd_addnorm #(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int EXPS_W = EXP_W + 2,
    localparam int LZ_W   = $clog2(EXT_W + 1)
) (
    input  logic                     eff_sub,
    input  logic [EXP_W-1:0]         big_exp,
    input  logic [EXT_W-1:0]         big_ext,
    input  logic [EXT_W-1:0]         small_ext,
    output logic [EXT_W-1:0]         norm_ext,
    output logic signed [EXPS_W-1:0] norm_exp,
    output logic                     is_zero
);

    logic [EXT_W:0]  raw;
    logic [LZ_W-1:0] lz;
    logic            seen;

    // Significand add or subtract with one carry bit.
    always_comb begin
        if (eff_sub) raw = {1'b0, big_ext} - {1'b0, small_ext};
        else         raw = {1'b0, big_ext} + {1'b0, small_ext};
        is_zero = (raw == '0);
    end

    // Leading-zero count below the carry position.
    always_comb begin
        lz   = '0;
        seen = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (raw[i]) seen = 1'b1;
                else        lz   = lz + LZ_W'(1);
            end
        end
    end

    // Normalising shift and exponent adjustment.
    always_comb begin
        if (raw[EXT_W]) begin
            norm_ext = {raw[EXT_W:2], |raw[1:0]};
            norm_exp = EXPS_W'({2'b00, big_exp}) + EXPS_W'(1);
        end else begin
            norm_ext = raw[EXT_W-1:0] << lz;
            norm_exp = EXPS_W'({2'b00, big_exp}) - EXPS_W'(lz);
        end
    end

endmodule

// File: rtl/fpadd_round.sv
// Rounds the normalised significand in the selected direction and repacks.
// Overflow saturates to infinity or to the largest finite value. Underflow
// flushes to a signed zero. An exact zero takes its sign from the mode.
// Assumes: norm_ext has its leading 1 in the top bit unless is_zero is set.
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int EXPS_W = EXP_W + 2,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  rnd_mode_e                mode,
    input  logic                     res_sign,
    input  logic                     is_zero,
    input  logic [EXT_W-1:0]         norm_ext,
    input  logic signed [EXPS_W-1:0] norm_exp,
    output logic [WORD_W-1:0]        word,
    output logic                     ovf,
    output logic                     unf
);

    localparam logic signed [EXPS_W-1:0] EXP_TOP = EXPS_W'(2 ** EXP_W - 1);
    localparam logic [EXP_W-1:0]         EXP_MAXF = EXP_W'(2 ** EXP_W - 2);

    logic                     inc;
    logic [SIG_W:0]           mant;
    logic signed [EXPS_W-1:0] exp_r;

    // Increment decision and carry into the exponent.
    always_comb begin
        inc   = need_increment(mode, res_sign, norm_ext[3], norm_ext[2], |norm_ext[1:0]);
        mant  = {1'b0, norm_ext[EXT_W-1:3]} + (SIG_W + 1)'(inc);
        exp_r = norm_exp + $signed({{(EXPS_W - 1){1'b0}}, mant[SIG_W]});
    end

    // Range handling and repacking.
    always_comb begin
        ovf = 1'b0;
        unf = 1'b0;
        if (is_zero) begin
            word = {(mode == RND_DOWN), {(WORD_W - 1){1'b0}}};
        end else if (exp_r >= EXP_TOP) begin
            ovf = 1'b1;
            if (overflow_to_inf(mode, res_sign))
                word = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            else
                word = {res_sign, EXP_MAXF, {FRAC_W{1'b1}}};
        end else if (exp_r <= 0) begin
            unf  = 1'b1;
            word = {res_sign, {(WORD_W - 1){1'b0}}};
        end else begin
            word = {res_sign, exp_r[EXP_W-1:0], mant[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fp32_adder.sv
// Floating-point adder top level: field split, align, add and normalise,
// round, then one output register stage. The result is registered one cycle
// after in_valid. Output value and flags hold while no new operation arrives.
// Assumes: operands are normal or zero (exponent field 0); all-ones exponents are not supplied.
module fp32_adder
    import fpadd_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int EXT_W  = SIG_W + 3,
    localparam int EXPS_W = EXP_W + 2,
    localparam int N_OPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [1:0]        rnd_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] sum,
    output logic              ovf_flag,
    output logic              unf_flag
);

    logic [N_OPS-1:0][WORD_W-1:0] ops;
    logic [N_OPS-1:0]             op_sign;
    logic [N_OPS-1:0][EXP_W-1:0]  op_exp;
    logic [N_OPS-1:0][SIG_W-1:0]  op_sig;
    logic [N_OPS-1:0]             op_zero;

    logic                     res_sign;
    logic                     eff_sub;
    logic [EXP_W-1:0]         big_exp;
    logic [EXT_W-1:0]         big_ext;
    logic [EXT_W-1:0]         small_ext;
    logic [EXT_W-1:0]         norm_ext;
    logic signed [EXPS_W-1:0] norm_exp;
    logic                     sum_zero;
    logic [WORD_W-1:0]        rnd_word;
    logic                     rnd_ovf;
    logic                     rnd_unf;

    assign ops = {op_b, op_a};

    // One field splitter per operand.
    for (genvar i = 0; i < N_OPS; i++) begin : g_split
        fpadd_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
            .word    (ops[i]),
            .sign    (op_sign[i]),
            .exp_f   (op_exp[i]),
            .sig     (op_sig[i]),
            .is_zero (op_zero[i])
        );
    end

    fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sign_a    (op_sign[0]),
        .exp_a     (op_exp[0]),
        .sig_a     (op_sig[0]),
        .sign_b    (op_sign[1]),
        .exp_b     (op_exp[1]),
        .sig_b     (op_sig[1]),
        .res_sign  (res_sign),
        .eff_sub   (eff_sub),
        .big_exp   (big_exp),
        .big_ext   (big_ext),
        .small_ext (small_ext)
    );

    fpadd_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
        .eff_sub   (eff_sub),
        .big_exp   (big_exp),
        .big_ext   (big_ext),
        .small_ext (small_ext),
        .norm_ext  (norm_ext),
        .norm_exp  (norm_exp),
        .is_zero   (sum_zero)
    );

    fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .mode      (rnd_mode_e'(rnd_mode)),
        .res_sign  (res_sign),
        .is_zero   (sum_zero),
        .norm_ext  (norm_ext),
        .norm_exp  (norm_exp),
        .word      (rnd_word),
        .ovf       (rnd_ovf),
        .unf       (rnd_unf)
    );

    // Output register stage: strobe every cycle, data only on a new operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum       <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum      <= rnd_word;
                ovf_flag <= rnd_ovf;
                unf_flag <= rnd_unf;
            end
        end
    end

    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(sum) && $stable(ovf_flag) && $stable(unf_flag)));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    // R7
    ovf_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag) |->
            (sum[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} ||
             sum[WORD_W-2:0] == {EXP_W'(2 ** EXP_W - 2), {FRAC_W{1'b1}}}));

    // R8
    unf_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf_flag) |-> (sum[WORD_W-2:0] == '0));

    // R8
    no_subnormal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sum[WORD_W-2 -: EXP_W] != '0 || sum[FRAC_W-1:0] == '0));

endmodule

// File: tb/tb_fp32_adder.sv
`timescale 1ns/1ps
module tb_fp32_adder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [1:0]  rnd_mode;
    logic        out_valid;
    logic [31:0] sum;
    logic        ovf_flag;
    logic        unf_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [34:0] exp_q[$];   // {valid, ovf, unf, sum}
    string       tag_q[$];
    logic [33:0] last_out;   // {ovf, unf, sum} of the last result

    always #2 clk = ~clk;    // 250 MHz

    fp32_adder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .rnd_mode  (rnd_mode),
        .out_valid (out_valid),
        .sum       (sum),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    // Exact wide-integer reference: returns {ovf, unf, sum}.
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] m);
        logic [319:0] va, vb, mag, tmp, mask;
        int ea, eb, emin, p, e;
        logic sa, sb, sg, half, stk, inc;
        logic [24:0] keep;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (ea == 0 && eb == 0) return {2'b00, (m == 2'd2), 31'd0};
        if (ea == 0) return {2'b00, b};
        if (eb == 0) return {2'b00, a};
        sa = a[31];
        sb = b[31];
        emin = (ea < eb) ? ea : eb;
        va = 320'({1'b1, a[22:0]}) << (ea - emin);
        vb = 320'({1'b1, b[22:0]}) << (eb - emin);
        if (sa == sb)      begin mag = va + vb; sg = sa; end
        else if (va >= vb) begin mag = va - vb; sg = sa; end
        else               begin mag = vb - va; sg = sb; end
        if (mag == '0) return {2'b00, (m == 2'd2), 31'd0};
        p = 0;
        for (int i = 0; i < 320; i++) if (mag[i]) p = i;
        e = emin + p - 23;
        if (p > 23) begin
            tmp  = mag >> (p - 23);
            keep = tmp[24:0];
            half = mag[p - 24];
            mask = (320'd1 << (p - 24)) - 320'd1;
            stk  = |(mag & mask);
        end else begin
            tmp  = mag << (23 - p);
            keep = tmp[24:0];
            half = 1'b0;
            stk  = 1'b0;
        end
        case (m)
            2'd0:    inc = half & (stk | keep[0]);
            2'd1:    inc = (half | stk) & ~sg;
            2'd2:    inc = (half | stk) & sg;
            default: inc = 1'b0;
        endcase
        keep = keep + 25'(inc);
        if (keep[24]) begin
            keep = keep >> 1;
            e = e + 1;
        end
        if (e >= 255) begin
            if (m == 2'd0 || (m == 2'd1 && !sg) || (m == 2'd2 && sg))
                return {2'b10, sg, 8'hFF, 23'd0};
            return {2'b10, sg, 8'hFE, 23'h7FFFFF};
        end
        if (e <= 0) return {2'b01, sg, 31'd0};
        return {2'b00, sg, 8'(e), keep[22:0]};
    endfunction

    // Compare the outputs against the expectation queued one cycle earlier.
    task automatic check_cycle();
        logic [34:0] e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (e[34]) begin
            if (out_valid !== 1'b1 || {ovf_flag, unf_flag, sum} !== e[33:0]) begin
                failures++;
                $display("FAIL %s: got v=%0b ovf=%0b unf=%0b sum=%08h, expected v=1 ovf=%0b unf=%0b sum=%08h",
                         t, out_valid, ovf_flag, unf_flag, sum, e[33], e[32], e[31:0]);
            end
            last_out = e[33:0];
        end else begin
            if (out_valid !== 1'b0 || {ovf_flag, unf_flag, sum} !== last_out) begin
                failures++;
                $display("FAIL %s: got v=%0b ovf=%0b unf=%0b sum=%08h, expected v=0 held %0b %0b %08h",
                         t, out_valid, ovf_flag, unf_flag, sum, last_out[33], last_out[32], last_out[31:0]);
            end
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input string tag);
        @(negedge clk);
        check_cycle();
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
        rnd_mode = m;
        exp_q.push_back({1'b1, model(a, b, m)});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        check_cycle();
        in_valid = 1'b0;
        op_a     = 32'hDEADBEEF;
        op_b     = 32'h12345678;
        exp_q.push_back(35'd0);
        tag_q.push_back("R1 R10 idle hold");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: run not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        int ea, eb;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        op_a     = '0;
        op_b     = '0;
        rnd_mode = 2'd0;
        last_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || sum !== 32'd0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got v=%0b sum=%08h ovf=%0b unf=%0b, expected all zero",
                     out_valid, sum, ovf_flag, unf_flag);
        end

        // R2 known pair in every direction
        apply(32'hF2D20004, 32'h76407020, 2'd0, "R2 known pair nearest");
        apply(32'hF2D20004, 32'h76407020, 2'd3, "R2 known pair toward zero");
        apply(32'h76407020, 32'hF2D20004, 2'd1, "R2 known pair up");
        apply(32'hF2D20004, 32'h76407020, 2'd2, "R2 known pair down");
        // R3 truncation lands on the truncated encoding
        apply(32'hBE99999A, 32'h2B800000, 2'd3, "R3 toward zero");
        apply(32'hBE99999A, 32'h2B800000, 2'd0, "R3 nearest");
        apply(32'hBE99999A, 32'h2B800000, 2'd2, "R3 down");
        apply(32'hBE99999A, 32'h2B800000, 2'd1, "R3 up");
        idle();
        idle();
        // R4 ties to even
        apply(32'h3F800000, 32'h33800000, 2'd0, "R4 tie even stays");
        apply(32'h3F800001, 32'h33800000, 2'd0, "R4 tie odd rounds up");
        apply(32'h3F800000, 32'h33800000, 2'd1, "R4 tie under up");
        // R5 zero-exponent operands
        apply(32'h3FC00000, 32'h00000000, 2'd0, "R5 plus zero");
        apply(32'h00400000, 32'hC0000000, 2'd1, "R5 flushed subnormal");
        // R6 exact zero
        apply(32'h40490FDB, 32'hC0490FDB, 2'd0, "R6 cancel nearest");
        apply(32'h40490FDB, 32'hC0490FDB, 2'd2, "R6 cancel down");
        apply(32'h80000000, 32'h80000000, 2'd3, "R6 two zeros");
        idle();
        // R7 overflow
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'd0, "R7 overflow nearest");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'd3, "R7 overflow toward zero");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'd2, "R7 overflow down positive");
        apply(32'hFF7FFFFF, 32'hFF7FFFFF, 2'd1, "R7 overflow up negative");
        apply(32'hFF7FFFFF, 32'hFF7FFFFF, 2'd2, "R7 overflow down negative");
        // R8 underflow
        apply(32'h00800001, 32'h80800000, 2'd0, "R8 underflow positive");
        apply(32'h80800001, 32'h00800000, 2'd1, "R8 underflow negative");
        // R9 large exponent difference
        apply(32'h3F800000, 32'h30800000, 2'd0, "R9 sticky nearest");
        apply(32'h3F800000, 32'h30800000, 2'd1, "R9 sticky up");
        apply(32'h3F800000, 32'h30800000, 2'd2, "R9 sticky down");
        apply(32'h30800000, 32'hBF800000, 2'd3, "R9 sticky swapped");
        idle();
        idle();

        // R2 mixed random operands, near and far exponents, with idle gaps
        for (int n = 0; n < 400; n++) begin
            ea = $urandom_range(1, 254);
            if ($urandom_range(0, 1) == 0) eb = $urandom_range(1, 254);
            else eb = ea + $urandom_range(0, 8) - 4;
            if (eb < 1) eb = 1;
            if (eb > 254) eb = 254;
            ra = {1'($urandom_range(0, 1)), 8'(ea), 23'($urandom)};
            rb = {1'($urandom_range(0, 1)), 8'(eb), 23'($urandom)};
            if ($urandom_range(0, 7) == 0) rb[22:0] = ra[22:0];
            apply(ra, rb, 2'($urandom_range(0, 3)), "R2 random");
            if ($urandom_range(0, 5) == 0) idle();
        end
        idle();
        idle();
        @(negedge clk);
        check_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule